// File: doc/BRIEF.md
# Host and Protocol Shared-Memory Arbiter

This block places one single-port memory array and a small register file between two masters: a host processor port and an internal bus-protocol engine port. At any time only one side owns the storage. When a host access collides with an engine memory cycle, the host is held off by an active-low ready output until the engine is done. When the engine asks for memory while the host holds it, the engine waits until the host ends its cycle. The protocol engine itself is outside this block.

Both ports follow a valid/ready discipline. The host raises `host_req` with its qualifiers (`host_reg`, `host_we`, `host_addr`, `host_wdata`) and keeps them stable until it samples `host_rdy_n` low. The transfer takes place in that cycle. The host keeps ownership for as long as `host_req` stays high and must drop it to let the engine in. The engine raises `eng_req` with stable qualifiers and the transfer takes place in the cycle where `eng_ack` is high. In the following cycle the engine either drops the request or presents a new one.

Two watchdog flags guard the time budgets. One flags a host that waited too long for ready. The other flags a host that kept the memory too long. The register file holds a mask register, a configuration register, a status register loaded by the engine and four externally implemented locations that are reached through strobes. A master-clear pin or a write to the clear location empties the internal registers.

Top module: `shmem_arb`

## Requirements
- R1: From idle, an engine request takes ownership (`eng_gnt` high) for exactly ENG_CYC cycles. Its transfer commits in the last of those cycles, which is the only one with `eng_ack` high.
- R2: While the engine owns the memory, `host_rdy_n` stays high. A host request that is pending when the engine cycle ends is granted in the very next cycle, ahead of any new engine request, and `host_rdy_n` is low in that first host cycle.
- R3: `stall_err` sets when a host request has waited more than STALL_MAX consecutive cycles without ownership. It stays set until `rst_n`.
- R4: Once the host owns the memory, it keeps ownership while `host_req` is high, and engine requests wait. Ownership returns to idle in the cycle after `host_req` is seen low. Each grant carries exactly one host transfer.
- R5: `host_late` sets when `host_req` is still high in a host-owned cycle after HOST_MAX owned cycles. It stays set until `rst_n`.
- R6: When host and engine requests are both pending in an idle cycle, the engine is granted.
- R7: `host_gnt` and `eng_gnt` are never high together.
- R8: When `host_reg` = 1, the host reaches the register space through `host_addr[2:0]`. Location 0 is the mask register and location 1 the configuration register, both read/write. Location 2 reads 0 and ignores writes. Location 3 is the clear location: write-only, reads 0. Locations 4 to 7 are external: `ext_stb[addr-4]` pulses in the transfer cycle and a read returns `ext_rdata`.
- R9: `mclr_n` low, or a host write to location 3, clears the mask, configuration and status registers by the next cycle. The clear wins over a simultaneous register or status write.
- R10: Host (`host_reg` = 0) and engine share one RAM array, so data written by either port is read back by the other. Read data is valid in the transfer cycle.
- R11: A `stat_we` pulse loads `stat_d` into `stat_q` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the whole block |
| mclr_n | input | 1 | Active-low master clear of the internal registers |
| host_req | input | 1 | Host request (valid) |
| host_reg | input | 1 | 1 selects the register space, 0 selects RAM |
| host_we | input | 1 | Host write enable |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| host_rdy_n | output | 1 | Active-low host ready; low marks the transfer cycle |
| host_gnt | output | 1 | Host owns the memory |
| host_rdata | output | DW | Host read data, valid while host_rdy_n is low |
| eng_req | input | 1 | Engine request (valid) |
| eng_we | input | 1 | Engine write enable |
| eng_addr | input | AW | Engine RAM address |
| eng_wdata | input | DW | Engine write data |
| eng_ack | output | 1 | Engine transfer cycle (ready) |
| eng_gnt | output | 1 | Engine owns the memory |
| eng_rdata | output | DW | Engine read data, valid while eng_ack is high |
| stat_we | input | 1 | Status register load strobe |
| stat_d | input | DW | Status register load value |
| cfg_q | output | DW | Configuration register |
| mask_q | output | DW | Interrupt mask register |
| stat_q | output | DW | Block status register |
| ext_stb | output | 4 | One-hot strobes for external locations 4 to 7 |
| ext_we | output | 1 | Write qualifier for ext_stb |
| ext_rdata | input | DW | Read data from the selected external location |
| stall_err | output | 1 | Sticky host-stall overrun flag |
| host_late | output | 1 | Sticky host-ownership overrun flag |

## Verification
The bench builds the block with ENG_CYC = 3, STALL_MAX = 3 and HOST_MAX = 4, with six address bits and 16-bit data. With these short budgets both watchdogs can be reached in a few cycles. A tied request waits one idle cycle plus a full engine cycle, which is four waiting cycles and crosses the stall limit. A host that holds its request a few extra cycles crosses the ownership limit. With an address range kept to eight RAM words, random overlapping traffic from both ports collides on the same locations all the time.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_ENG  = 2'd1,
    OWN_HOST = 2'd2
  } own_e;

  localparam int RSEL_W = 3;
  localparam logic [RSEL_W-1:0] RA_MASK  = 3'd0;
  localparam logic [RSEL_W-1:0] RA_CFG   = 3'd1;
  localparam logic [RSEL_W-1:0] RA_NONE  = 3'd2;
  localparam logic [RSEL_W-1:0] RA_CLEAR = 3'd3;
  localparam int EXT_N = 4;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int ENG_CYC   = 4,
  parameter int STALL_MAX = 90,
  parameter int HOST_MAX  = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic eng_req,
  output logic host_gnt,
  output logic eng_gnt,
  output logic host_fire,
  output logic host_rdy_n,
  output logic eng_ack,
  output logic stall_err,
  output logic host_late
);
  localparam int ECW = $clog2(ENG_CYC + 1);
  localparam int SCW = $clog2(STALL_MAX + 1);
  localparam int HCW = $clog2(HOST_MAX + 1);
  localparam logic [ECW-1:0] E_LOAD = ECW'(ENG_CYC);
  localparam logic [ECW-1:0] E_LAST = ECW'(1);
  localparam logic [SCW-1:0] S_LIM  = SCW'(STALL_MAX);
  localparam logic [HCW-1:0] H_LIM  = HCW'(HOST_MAX);

  own_e           own;
  logic           hdone;
  logic [ECW-1:0] eleft;
  logic [SCW-1:0] scnt;
  logic [HCW-1:0] hcnt;
  logic           waiting;

  assign host_gnt   = (own == OWN_HOST);
  assign eng_gnt    = (own == OWN_ENG);
  assign host_fire  = host_gnt && !hdone;
  assign host_rdy_n = !host_fire;
  assign eng_ack    = eng_gnt && (eleft == E_LAST);
  assign waiting    = host_req && !host_gnt;

  // ownership sequencing: engine wins ties in idle, host follows an engine cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own   <= OWN_IDLE;
      hdone <= 1'b0;
      eleft <= '0;
    end else begin
      unique case (own)
        OWN_IDLE: begin
          if (eng_req) begin
            own   <= OWN_ENG;
            eleft <= E_LOAD;
          end else if (host_req) begin
            own   <= OWN_HOST;
            hdone <= 1'b0;
          end
        end
        OWN_ENG: begin
          if (eleft == E_LAST) begin
            own   <= host_req ? OWN_HOST : OWN_IDLE;
            hdone <= 1'b0;
          end else begin
            eleft <= eleft - E_LAST;
          end
        end
        OWN_HOST: begin
          if (!hdone) hdone <= 1'b1;
          else if (!host_req) own <= OWN_IDLE;
        end
        default: own <= OWN_IDLE;
      endcase
    end
  end

  // time budget watchdogs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt      <= '0;
      hcnt      <= '0;
      stall_err <= 1'b0;
      host_late <= 1'b0;
    end else begin
      if (waiting) begin
        if (scnt != S_LIM) scnt <= scnt + SCW'(1);
      end else begin
        scnt <= '0;
      end
      if (waiting && scnt == S_LIM) stall_err <= 1'b1;

      if (host_gnt) begin
        if (hcnt != H_LIM) hcnt <= hcnt + HCW'(1);
      end else begin
        hcnt <= '0;
      end
      if (host_gnt && host_req && hcnt == H_LIM) host_late <= 1'b1;
    end
  end
endmodule

// File: rtl/arb_regs.sv
module arb_regs
  import arb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr_n,
  input  logic              acc_en,
  input  logic              wr_en,
  input  logic [RSEL_W-1:0] sel,
  input  logic [DW-1:0]     wdata,
  input  logic              stat_we,
  input  logic [DW-1:0]     stat_d,
  input  logic [DW-1:0]     ext_rdata,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     cfg_q,
  output logic [DW-1:0]     mask_q,
  output logic [DW-1:0]     stat_q,
  output logic [EXT_N-1:0]  ext_stb
);
  logic clr;

  assign clr = !mclr_n || (wr_en && sel == RA_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else if (clr) begin
      cfg_q  <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_en && sel == RA_MASK) mask_q <= wdata;
      if (wr_en && sel == RA_CFG)  cfg_q  <= wdata;
      if (stat_we)                 stat_q <= stat_d;
    end
  end

  always_comb begin
    if (sel[RSEL_W-1]) begin
      rdata = ext_rdata;
    end else begin
      unique case (sel)
        RA_MASK: rdata = mask_q;
        RA_CFG:  rdata = cfg_q;
        default: rdata = '0;
      endcase
    end
  end

  for (genvar g = 0; g < EXT_N; g++) begin : g_ext
    assign ext_stb[g] = acc_en && sel[RSEL_W-1] && (sel[RSEL_W-2:0] == 2'(g));
  end
endmodule

// File: rtl/arb_ram.sv
module arb_ram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/shmem_arb.sv
module shmem_arb
  import arb_pkg::*;
#(
  parameter int AW        = 6,
  parameter int DW        = 16,
  parameter int ENG_CYC   = 4,
  parameter int STALL_MAX = 90,
  parameter int HOST_MAX  = 75
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mclr_n,
  input  logic          host_req,
  input  logic          host_reg,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_rdy_n,
  output logic          host_gnt,
  output logic [DW-1:0] host_rdata,
  input  logic          eng_req,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [DW-1:0] eng_wdata,
  output logic          eng_ack,
  output logic          eng_gnt,
  output logic [DW-1:0] eng_rdata,
  input  logic          stat_we,
  input  logic [DW-1:0] stat_d,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] stat_q,
  output logic [3:0]    ext_stb,
  output logic          ext_we,
  input  logic [DW-1:0] ext_rdata,
  output logic          stall_err,
  output logic          host_late
);
  logic          host_fire;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata;
  logic [DW-1:0] reg_rdata;

  arb_ctrl #(
    .ENG_CYC  (ENG_CYC),
    .STALL_MAX(STALL_MAX),
    .HOST_MAX (HOST_MAX)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_req  (host_req),
    .eng_req   (eng_req),
    .host_gnt  (host_gnt),
    .eng_gnt   (eng_gnt),
    .host_fire (host_fire),
    .host_rdy_n(host_rdy_n),
    .eng_ack   (eng_ack),
    .stall_err (stall_err),
    .host_late (host_late)
  );

  arb_regs #(.DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .mclr_n   (mclr_n),
    .acc_en   (host_fire && host_reg),
    .wr_en    (host_fire && host_reg && host_we),
    .sel      (host_addr[RSEL_W-1:0]),
    .wdata    (host_wdata),
    .stat_we  (stat_we),
    .stat_d   (stat_d),
    .ext_rdata(ext_rdata),
    .rdata    (reg_rdata),
    .cfg_q    (cfg_q),
    .mask_q   (mask_q),
    .stat_q   (stat_q),
    .ext_stb  (ext_stb)
  );

  // single RAM port steered by the current owner
  assign ram_addr  = eng_gnt ? eng_addr : host_addr;
  assign ram_wdata = eng_gnt ? eng_wdata : host_wdata;
  assign ram_we    = (eng_ack && eng_we) || (host_fire && !host_reg && host_we);

  arb_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  assign host_rdata = host_reg ? reg_rdata : ram_rdata;
  assign eng_rdata  = ram_rdata;
  assign ext_we     = host_we;
endmodule

// File: rtl/shmem_arb_chk.sv
module shmem_arb_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mclr_n,
  input logic          host_req,
  input logic          eng_req,
  input logic          host_rdy_n,
  input logic          host_gnt,
  input logic          eng_gnt,
  input logic          eng_ack,
  input logic [DW-1:0] cfg_q,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] stat_q,
  input logic [3:0]    ext_stb,
  input logic          stall_err,
  input logic          host_late
);
  a_r7_mutex: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_gnt && eng_gnt));

  a_r1_ack_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
    eng_ack |-> eng_gnt);

  a_r2_host_held: assert property (@(posedge clk) disable iff (!rst_n)
    eng_gnt |-> host_rdy_n);

  a_r2_host_next: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_ack && host_req) |=> (host_gnt && !host_rdy_n));

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stall_err |=> stall_err);

  a_r4_keep_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && host_req) |=> (host_gnt && !eng_gnt));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    host_late |=> host_late);

  a_r6_eng_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_gnt && !eng_gnt && eng_req && host_req) |=> (eng_gnt && !host_gnt));

  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_stb));

  a_r8_stb_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_stb) |-> !host_rdy_n);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !mclr_n |=> (cfg_q == '0 && mask_q == '0 && stat_q == '0));
endmodule

bind shmem_arb shmem_arb_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mclr_n    (mclr_n),
  .host_req  (host_req),
  .eng_req   (eng_req),
  .host_rdy_n(host_rdy_n),
  .host_gnt  (host_gnt),
  .eng_gnt   (eng_gnt),
  .eng_ack   (eng_ack),
  .cfg_q     (cfg_q),
  .mask_q    (mask_q),
  .stat_q    (stat_q),
  .ext_stb   (ext_stb),
  .stall_err (stall_err),
  .host_late (host_late)
);

// File: tb/shmem_arb_bench.sv
module shmem_arb_bench;
  localparam int AW   = 6;
  localparam int DW   = 16;
  localparam int ECYC = 3;
  localparam int SMAX = 3;
  localparam int HMAX = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mclr_n = 1'b1;
  logic          host_req = 1'b0, host_reg = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_rdy_n, host_gnt;
  logic [DW-1:0] host_rdata;
  logic          eng_req = 1'b0, eng_we = 1'b0;
  logic [AW-1:0] eng_addr = '0;
  logic [DW-1:0] eng_wdata = '0;
  logic          eng_ack, eng_gnt;
  logic [DW-1:0] eng_rdata;
  logic          stat_we = 1'b0;
  logic [DW-1:0] stat_d = '0;
  logic [DW-1:0] cfg_q, mask_q, stat_q;
  logic [3:0]    ext_stb;
  logic          ext_we;
  logic [DW-1:0] ext_rdata = 16'h5A5A;
  logic          stall_err, host_late;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 0;

  // reference model state
  int            m_own = 0;   // 0 idle, 1 engine, 2 host
  int            m_eleft = 0;
  bit            m_hdone = 0;
  int            m_wcnt = 0;
  int            m_hold = 0;
  bit            m_serr = 0;
  bit            m_late = 0;
  logic [DW-1:0] m_cfg = '0, m_mask = '0, m_stat = '0;
  logic [DW-1:0] m_mem [int];

  always #10 clk = ~clk;

  shmem_arb #(
    .AW(AW), .DW(DW), .ENG_CYC(ECYC), .STALL_MAX(SMAX), .HOST_MAX(HMAX)
  ) u_shmem_arb (
    .clk(clk), .rst_n(rst_n), .mclr_n(mclr_n),
    .host_req(host_req), .host_reg(host_reg), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdy_n(host_rdy_n), .host_gnt(host_gnt), .host_rdata(host_rdata),
    .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .eng_ack(eng_ack), .eng_gnt(eng_gnt), .eng_rdata(eng_rdata),
    .stat_we(stat_we), .stat_d(stat_d),
    .cfg_q(cfg_q), .mask_q(mask_q), .stat_q(stat_q),
    .ext_stb(ext_stb), .ext_we(ext_we), .ext_rdata(ext_rdata),
    .stall_err(stall_err), .host_late(host_late)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    bit wt, hf, ef;
    if (!rst_n) begin
      m_own = 0; m_eleft = 0; m_hdone = 0; m_wcnt = 0; m_hold = 0;
      m_serr = 0; m_late = 0; m_cfg = '0; m_mask = '0; m_stat = '0;
    end else begin
      wt = host_req && (m_own != 2);
      hf = (m_own == 2) && !m_hdone;
      ef = (m_own == 1) && (m_eleft == 1);
      if (wt && m_wcnt >= SMAX) m_serr = 1;
      if (m_own == 2 && host_req && m_hold >= HMAX) m_late = 1;
      m_wcnt = wt ? m_wcnt + 1 : 0;
      m_hold = (m_own == 2) ? m_hold + 1 : 0;
      if (hf && !host_reg && host_we) m_mem[int'(host_addr)] = host_wdata;
      if (ef && eng_we) m_mem[int'(eng_addr)] = eng_wdata;
      if (!mclr_n || (hf && host_reg && host_we && host_addr[2:0] == 3'd3)) begin
        m_cfg = '0; m_mask = '0; m_stat = '0;
      end else begin
        if (hf && host_reg && host_we && host_addr[2:0] == 3'd0) m_mask = host_wdata;
        if (hf && host_reg && host_we && host_addr[2:0] == 3'd1) m_cfg = host_wdata;
        if (stat_we) m_stat = stat_d;
      end
      if (m_own == 0) begin
        if (eng_req) begin m_own = 1; m_eleft = ECYC; end
        else if (host_req) begin m_own = 2; m_hdone = 0; end
      end else if (m_own == 1) begin
        if (m_eleft == 1) begin m_own = host_req ? 2 : 0; m_hdone = 0; end
        else m_eleft--;
      end else begin
        if (!m_hdone) m_hdone = 1;
        else if (!host_req) m_own = 0;
      end
    end
  end

  // compare against the model in the middle of each low phase
  always @(negedge clk) begin
    logic [DW-1:0] ex;
    #2;
    if (cmp_on) begin
      chk("R7 grants exclusive", 32'(host_gnt && eng_gnt), 32'd0);
      chk("R4 host grant", 32'(host_gnt), 32'(m_own == 2));
      chk("R1 engine grant", 32'(eng_gnt), 32'(m_own == 1));
      chk("R1 engine ack", 32'(eng_ack), 32'(m_own == 1 && m_eleft == 1));
      chk("R2 host ready", 32'(host_rdy_n), 32'(!(m_own == 2 && !m_hdone)));
      chk("R3 stall flag", 32'(stall_err), 32'(m_serr));
      chk("R5 late flag", 32'(host_late), 32'(m_late));
      chk("R9 config reg", 32'(cfg_q), 32'(m_cfg));
      chk("R9 mask reg", 32'(mask_q), 32'(m_mask));
      chk("R11 status reg", 32'(stat_q), 32'(m_stat));
      ex = '0;
      if (m_own == 2 && !m_hdone && host_reg && host_addr[2]) ex[host_addr[1:0]] = 1'b1;
      chk("R8 ext strobe", 32'(ext_stb), 32'(ex[3:0]));
      if (!host_rdy_n) begin
        if (host_reg) begin
          case (host_addr[2:0])
            3'd0: ex = m_mask;
            3'd1: ex = m_cfg;
            3'd2, 3'd3: ex = '0;
            default: ex = ext_rdata;
          endcase
          chk("R8 register read", 32'(host_rdata), 32'(ex));
        end else if (m_mem.exists(int'(host_addr))) begin
          chk("R10 host ram read", 32'(host_rdata), 32'(m_mem[int'(host_addr)]));
        end
      end
      if (eng_ack && m_mem.exists(int'(eng_addr)))
        chk("R10 engine ram read", 32'(eng_rdata), 32'(m_mem[int'(eng_addr)]));
    end
  end

  task automatic do_reset();
    @(negedge clk);
    cmp_on = 0; rst_n = 0; host_req = 0; eng_req = 0; stat_we = 0; mclr_n = 1;
    repeat (2) @(negedge clk);
    rst_n = 1; cmp_on = 1;
  endtask

  task automatic host_xfer(input logic r, input logic w, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input int hold,
                           output logic [DW-1:0] q);
    int waits = 0;
    @(negedge clk);
    host_req = 1; host_reg = r; host_we = w; host_addr = a; host_wdata = d;
    do begin
      @(negedge clk);
      waits++;
    end while (host_rdy_n && waits < 50);
    q = host_rdata;
    if (waits > ECYC + 2) chk("R2 host eventually granted", 32'(waits), 32'(ECYC + 2));
    repeat (hold) @(negedge clk);
    @(negedge clk);
    host_req = 0;
  endtask

  task automatic eng_xfer(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] q);
    int waits = 0;
    @(negedge clk);
    eng_req = 1; eng_we = w; eng_addr = a; eng_wdata = d;
    do begin
      @(negedge clk);
      waits++;
    end while (!eng_ack && waits < 50);
    q = eng_rdata;
    if (waits > 12) chk("R4 engine eventually granted", 32'(waits), 32'd12);
    @(negedge clk);
    eng_req = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [DW-1:0] q;
    do_reset();
    #3;
    chk("R9 reset config", 32'(cfg_q), 32'd0);
    chk("R9 reset mask", 32'(mask_q), 32'd0);
    chk("R2 reset ready high", 32'(host_rdy_n), 32'd1);
    chk("R3 reset stall flag", 32'(stall_err), 32'd0);

    // R10 / R1: cross-port RAM traffic
    eng_xfer(1, 6'd5, 16'hA1B2, q);
    host_xfer(0, 0, 6'd5, '0, 0, q);
    chk("R10 host sees engine write", 32'(q), 32'hA1B2);
    host_xfer(0, 1, 6'd6, 16'h3C4D, 0, q);
    eng_xfer(0, 6'd6, '0, q);
    chk("R10 engine sees host write", 32'(q), 32'h3C4D);

    // R8: register map
    host_xfer(1, 1, 6'd0, 16'h1234, 0, q);
    host_xfer(1, 1, 6'd1, 16'hBEEF, 0, q);
    host_xfer(1, 1, 6'd2, 16'hFFFF, 0, q);
    host_xfer(1, 0, 6'd2, '0, 0, q);
    chk("R8 unused reads zero", 32'(q), 32'd0);
    host_xfer(1, 0, 6'd0, '0, 0, q);
    chk("R8 mask read back", 32'(q), 32'h1234);
    host_xfer(1, 0, 6'd1, '0, 0, q);
    chk("R8 config read back", 32'(q), 32'hBEEF);
    host_xfer(1, 0, 6'd3, '0, 0, q);
    chk("R8 clear location reads zero", 32'(q), 32'd0);
    host_xfer(1, 0, 6'd5, '0, 0, q);
    chk("R8 external read", 32'(q), 32'h5A5A);

    // R11 then R9 clear by write
    @(negedge clk); stat_we = 1; stat_d = 16'h00F0;
    @(negedge clk); stat_we = 0; #3;
    chk("R11 status loaded", 32'(stat_q), 32'h00F0);
    host_xfer(1, 1, 6'd3, 16'h0001, 0, q);
    #3;
    chk("R9 write clear config", 32'(cfg_q), 32'd0);
    chk("R9 write clear mask", 32'(mask_q), 32'd0);
    chk("R9 write clear status", 32'(stat_q), 32'd0);

    // R9 master clear beats a status load
    host_xfer(1, 1, 6'd1, 16'h0F0F, 0, q);
    @(negedge clk); mclr_n = 0; stat_we = 1; stat_d = 16'h7777;
    @(negedge clk); mclr_n = 1; stat_we = 0; #3;
    chk("R9 master clear config", 32'(cfg_q), 32'd0);
    chk("R9 master clear status", 32'(stat_q), 32'd0);

    // R2 / R3: host arrives one cycle into an engine cycle, stall within budget
    fork
      eng_xfer(1, 6'd7, 16'h0707, q);
      begin logic [DW-1:0] hq; @(negedge clk); host_xfer(0, 0, 6'd7, '0, 0, hq);
        chk("R2 host read after engine", 32'(hq), 32'h0707); end
    join
    #3;
    chk("R3 no stall flag within budget", 32'(stall_err), 32'd0);

    // R6 / R3: tie goes to the engine, stall exceeds budget
    fork
      eng_xfer(1, 6'd1, 16'h1111, q);
      begin logic [DW-1:0] hq; host_xfer(0, 1, 6'd1, 16'h2222, 0, hq); end
      begin @(negedge clk); @(negedge clk); #3;
        chk("R6 engine wins tie", 32'(eng_gnt), 32'd1);
        chk("R6 host not granted on tie", 32'(host_gnt), 32'd0); end
    join
    #3;
    chk("R3 stall flag set", 32'(stall_err), 32'd1);
    do_reset();

    // R4 / R5: host holds ownership beyond budget, engine must wait
    fork
      host_xfer(0, 1, 6'd2, 16'h4444, 5, q);
      begin logic [DW-1:0] eq; repeat (3) @(negedge clk); eng_xfer(0, 6'd2, '0, eq);
        chk("R4 engine reads after host", 32'(eq), 32'h4444); end
      begin repeat (10) begin @(negedge clk); #3;
        if (host_gnt && host_req) chk("R4 engine held off", 32'(eng_gnt), 32'd0); end end
    join
    #3;
    chk("R5 late flag set", 32'(host_late), 32'd1);
    do_reset();
    #3;
    chk("R5 late flag cleared by reset", 32'(host_late), 32'd0);

    // random overlapping traffic on a narrow address window
    ext_rdata = 16'hC3A5;
    fork
      for (int i = 0; i < 250; i++) begin
        logic [DW-1:0] hq;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        host_xfer(($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                  AW'($urandom_range(0, 7)), DW'($urandom), 0, hq);
      end
      for (int i = 0; i < 250; i++) begin
        logic [DW-1:0] eq;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        eng_xfer(1'($urandom_range(0, 1)), AW'($urandom_range(0, 7)), DW'($urandom), eq);
      end
      for (int i = 0; i < 60; i++) begin
        repeat ($urandom_range(5, 20)) @(negedge clk);
        stat_we = 1; stat_d = DW'($urandom);
        @(negedge clk); stat_we = 0;
      end
    join
    repeat (4) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule